// File: doc/BRIEF.md
# Fixed-Point Carry, Overflow and Condition Flag Unit

This block evaluates the fixed-point status flags that follow an integer operation. It does not perform the operation: it receives the operands the operation consumed, the result it produced, and a few control bits, and from these it works out the carry (64-bit and 32-bit), the overflow (64-bit and 32-bit), the sticky summary overflow, and a 4-bit condition field describing the sign of the result. Carry is found by comparing, unsigned, each operand against the result. Additions use a parity rule at bit 32 for the 32-bit carry. Overflow is found from operand and result signs, or taken directly from a divider.

The operand list is formed from up to three register operands, used in order, followed by an optional immediate. The first register operand may be bitwise inverted before any flag is evaluated. The flags sit in a register that changes only on an update strobe. Each group of flags (carry, overflow, condition field) has its own enable. A two-bit mask lets an instruction that has already produced its own carry values keep the held carry bits unchanged.

Top module: `fxflag_unit`

## Requirements
- R1: A synchronous active-high reset clears ca, ca32, ov, ov32, so and cr0 to zero on the next clock edge.
- R2: When upd_valid is low, no output changes at the clock edge.
- R3: The operand list holds the first opnd_cnt (0 to 3) of opnd_a, opnd_b, opnd_c, in that order, then imm_data as the last entry when imm_valid is high. opnd_a is bitwise inverted first when inv_a is high and opnd_cnt is at least 1.
- R4: On an update with carry_en high and done_mask bit 0 clear, ca becomes 1 if any listed operand is unsigned-greater than result, else 0. With done_mask bit 0 set, ca is held.
- R5: On an update with carry_en high and done_mask bit 1 clear, ca32 is set as follows. When is_add is high, ca32 = result[32] ^ op0[32] ^ op1[32], where a missing list entry counts as 0. Otherwise ca32 is 1 if bits [31:0] of any listed operand are unsigned-greater than result[31:0]. With done_mask bit 1 set, ca32 is held.
- R6: On an update with ovf_en high, divovf_valid low and at least two listed operands, ov is 1 when op0[63] equals op1[63] and result[63] differs from them. ov32 applies the same rule to bit 31.
- R7: On an update with ovf_en and divovf_valid high, both ov and ov32 take divovf_val, whatever the operand count.
- R8: On an update with ovf_en high, divovf_valid low and fewer than two listed operands, ov, ov32 and so are held.
- R9: Whenever overflow is evaluated (R6 or R7), so becomes so OR the new ov. Only reset clears so.
- R10: On an update with rec_en high, cr0 becomes {negative, positive, zero, so} (bit 3 down to bit 0) of the signed 64-bit result. Bit 0 carries so after any update in the same edge. With rec_en low, cr0 is held.
- R11: On an update with carry_en low, ca and ca32 are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_valid | input | 1 | Update strobe for the flag register |
| opnd_a | input | 64 | First register operand |
| opnd_b | input | 64 | Second register operand |
| opnd_c | input | 64 | Third register operand |
| opnd_cnt | input | 2 | Number of register operands in use (0 to 3) |
| inv_a | input | 1 | Invert the first register operand |
| imm_valid | input | 1 | Immediate is appended to the operand list |
| imm_data | input | 64 | Immediate operand |
| result | input | 64 | Result of the operation |
| is_add | input | 1 | Operation is an addition (selects the ca32 rule) |
| carry_en | input | 1 | Evaluate ca and ca32 |
| ovf_en | input | 1 | Evaluate ov, ov32 and so |
| rec_en | input | 1 | Record the condition field cr0 |
| divovf_valid | input | 1 | A divider overflow value is supplied |
| divovf_val | input | 1 | Divider overflow value |
| done_mask | input | 2 | Bit 0 holds ca, bit 1 holds ca32 |
| ca | output | 1 | 64-bit carry |
| ca32 | output | 1 | 32-bit carry |
| ov | output | 1 | 64-bit overflow |
| ov32 | output | 1 | 32-bit overflow |
| so | output | 1 | Sticky summary overflow |
| cr0 | output | 4 | Condition field {neg, pos, zero, so} |

## Verification
Every flag is a registered output, so a bad next-state decision shows on the ports one edge after the strobe that caused it. A wrong operand slot, such as a missed inversion or an immediate that is not counted, changes ca or ca32 in that same cycle. The cases are chosen so the wrong list gives the opposite answer. A lost sticky so shows on so and on cr0 bit 0 at the next update, even when that update has no overflow. Hold behaviour (no strobe, disabled groups, mask bits, too few operands) is checked by choosing inputs that would flip the held flag if it were wrongly written.

// File: rtl/fxflag_pkg.sv
package fxflag_pkg;

    localparam int XLEN      = 64;
    localparam int HALF      = XLEN / 2;
    localparam int NREG_OPS  = 3;
    localparam int NSLOT     = NREG_OPS + 1;
    localparam int CNT_W     = $clog2(NREG_OPS + 1);
    localparam int CR_W      = 4;

    // bit positions inside the condition field
    localparam int CR_NEG  = 3;
    localparam int CR_POS  = 2;
    localparam int CR_ZERO = 1;
    localparam int CR_SO   = 0;

    typedef enum logic [1:0] {
        OVS_HOLD  = 2'd0,
        OVS_ARITH = 2'd1,
        OVS_DIV   = 2'd2
    } ovf_src_e;

    typedef struct packed {
        logic            ca;
        logic            ca32;
        logic            ov;
        logic            ov32;
        logic            so;
        logic [CR_W-1:0] cr0;
    } fx_flags_t;

    localparam fx_flags_t FLAGS_CLEAR = '0;

    // signed overflow from sign bits: operands agree, result disagrees
    function automatic logic sign_ovf(input logic s0, input logic s1, input logic sr);
        return (s0 == s1) && (sr != s0);
    endfunction

endpackage

// File: rtl/fxflag_oplist.sv
module fxflag_oplist
    import fxflag_pkg::*;
(
    input  logic [NREG_OPS-1:0][XLEN-1:0] regs,
    input  logic [CNT_W-1:0]              opnd_cnt,
    input  logic                          inv_a,
    input  logic                          imm_valid,
    input  logic [XLEN-1:0]               imm_data,
    output logic [NSLOT-1:0][XLEN-1:0]    ops,
    output logic [NSLOT-1:0]              live
);

    genvar k;
    generate
        for (k = 0; k < NSLOT; k++) begin : g_slot
            logic from_reg;
            logic from_imm;
            assign from_imm = imm_valid && (int'(opnd_cnt) == k);
            if (k < NREG_OPS) begin : g_reg
                logic [XLEN-1:0] rv;
                assign from_reg = (k < int'(opnd_cnt));
                if (k == 0) begin : g_first
                    assign rv = inv_a ? ~regs[k] : regs[k];
                end else begin : g_other
                    assign rv = regs[k];
                end
                assign ops[k] = from_reg ? rv : (from_imm ? imm_data : '0);
            end else begin : g_tail
                assign from_reg = 1'b0;
                assign ops[k]   = from_imm ? imm_data : '0;
            end
            assign live[k] = from_reg || from_imm;
        end
    endgenerate

endmodule

// File: rtl/fxflag_carry.sv
module fxflag_carry
    import fxflag_pkg::*;
(
    input  logic [NSLOT-1:0][XLEN-1:0] ops,
    input  logic [NSLOT-1:0]           live,
    input  logic [XLEN-1:0]            result,
    input  logic                       is_add,
    output logic                       ca_new,
    output logic                       ca32_new
);

    logic [NSLOT-1:0] gt_full;
    logic [NSLOT-1:0] gt_low;

    genvar k;
    generate
        for (k = 0; k < NSLOT; k++) begin : g_cmp
            assign gt_full[k] = live[k] && (ops[k] > result);
            assign gt_low[k]  = live[k] && (ops[k][HALF-1:0] > result[HALF-1:0]);
        end
    endgenerate

    logic add_par;
    assign add_par = result[HALF]
                   ^ (live[0] & ops[0][HALF])
                   ^ (live[1] & ops[1][HALF]);

    assign ca_new   = |gt_full;
    assign ca32_new = is_add ? add_par : (|gt_low);

endmodule

// File: rtl/fxflag_ovf.sv
module fxflag_ovf
    import fxflag_pkg::*;
(
    input  logic     ovf_en,
    input  logic     two_plus,
    input  logic     divovf_valid,
    input  logic     divovf_val,
    input  logic     op0_s64,
    input  logic     op1_s64,
    input  logic     res_s64,
    input  logic     op0_s32,
    input  logic     op1_s32,
    input  logic     res_s32,
    output ovf_src_e src,
    output logic     ov_new,
    output logic     ov32_new
);

    always_comb begin
        if (!ovf_en)           src = OVS_HOLD;
        else if (divovf_valid) src = OVS_DIV;
        else if (two_plus)     src = OVS_ARITH;
        else                   src = OVS_HOLD;
    end

    always_comb begin
        unique case (src)
            OVS_DIV: begin
                ov_new   = divovf_val;
                ov32_new = divovf_val;
            end
            OVS_ARITH: begin
                ov_new   = sign_ovf(op0_s64, op1_s64, res_s64);
                ov32_new = sign_ovf(op0_s32, op1_s32, res_s32);
            end
            default: begin
                ov_new   = 1'b0;
                ov32_new = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/fxflag_cr.sv
module fxflag_cr
    import fxflag_pkg::*;
(
    input  logic [XLEN-1:0] result,
    input  logic            so_next,
    output logic [CR_W-1:0] cr_new
);

    logic is_zero;
    logic is_neg;

    assign is_zero = (result == '0);
    assign is_neg  = result[XLEN-1];

    always_comb begin
        cr_new          = '0;
        cr_new[CR_NEG]  = is_neg;
        cr_new[CR_POS]  = !is_neg && !is_zero;
        cr_new[CR_ZERO] = is_zero;
        cr_new[CR_SO]   = so_next;
    end

endmodule

// File: rtl/fxflag_unit.sv
module fxflag_unit
    import fxflag_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 upd_valid,
    input  logic [XLEN-1:0]      opnd_a,
    input  logic [XLEN-1:0]      opnd_b,
    input  logic [XLEN-1:0]      opnd_c,
    input  logic [CNT_W-1:0]     opnd_cnt,
    input  logic                 inv_a,
    input  logic                 imm_valid,
    input  logic [XLEN-1:0]      imm_data,
    input  logic [XLEN-1:0]      result,
    input  logic                 is_add,
    input  logic                 carry_en,
    input  logic                 ovf_en,
    input  logic                 rec_en,
    input  logic                 divovf_valid,
    input  logic                 divovf_val,
    input  logic [1:0]           done_mask,
    output logic                 ca,
    output logic                 ca32,
    output logic                 ov,
    output logic                 ov32,
    output logic                 so,
    output logic [CR_W-1:0]      cr0
);

    logic [NREG_OPS-1:0][XLEN-1:0] regs;
    logic [NSLOT-1:0][XLEN-1:0]    ops;
    logic [NSLOT-1:0]              live;

    assign regs[0] = opnd_a;
    assign regs[1] = opnd_b;
    assign regs[2] = opnd_c;

    fxflag_oplist u_oplist (
        .regs      (regs),
        .opnd_cnt  (opnd_cnt),
        .inv_a     (inv_a),
        .imm_valid (imm_valid),
        .imm_data  (imm_data),
        .ops       (ops),
        .live      (live)
    );

    logic ca_new;
    logic ca32_new;

    fxflag_carry u_carry (
        .ops      (ops),
        .live     (live),
        .result   (result),
        .is_add   (is_add),
        .ca_new   (ca_new),
        .ca32_new (ca32_new)
    );

    ovf_src_e ovf_src;
    logic     ov_new;
    logic     ov32_new;

    fxflag_ovf u_ovf (
        .ovf_en       (ovf_en),
        .two_plus     (live[1]),
        .divovf_valid (divovf_valid),
        .divovf_val   (divovf_val),
        .op0_s64      (ops[0][XLEN-1]),
        .op1_s64      (ops[1][XLEN-1]),
        .res_s64      (result[XLEN-1]),
        .op0_s32      (ops[0][HALF-1]),
        .op1_s32      (ops[1][HALF-1]),
        .res_s32      (result[HALF-1]),
        .src          (ovf_src),
        .ov_new       (ov_new),
        .ov32_new     (ov32_new)
    );

    fx_flags_t cur;
    fx_flags_t nxt;
    logic      ovf_eval;
    logic      so_next;
    logic [CR_W-1:0] cr_new;

    assign ovf_eval = upd_valid && (ovf_src != OVS_HOLD);
    assign so_next  = ovf_eval ? (cur.so | ov_new) : cur.so;

    fxflag_cr u_cr (
        .result  (result),
        .so_next (so_next),
        .cr_new  (cr_new)
    );

    always_comb begin
        nxt = cur;
        if (upd_valid) begin
            if (carry_en) begin
                if (!done_mask[0]) nxt.ca   = ca_new;
                if (!done_mask[1]) nxt.ca32 = ca32_new;
            end
            if (ovf_eval) begin
                nxt.ov   = ov_new;
                nxt.ov32 = ov32_new;
            end
            nxt.so = so_next;
            if (rec_en) nxt.cr0 = cr_new;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= FLAGS_CLEAR;
        else     cur <= nxt;
    end

    assign ca   = cur.ca;
    assign ca32 = cur.ca32;
    assign ov   = cur.ov;
    assign ov32 = cur.ov32;
    assign so   = cur.so;
    assign cr0  = cur.cr0;

endmodule

// File: rtl/fxflag_unit_chk.sv
module fxflag_unit_chk
    import fxflag_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             upd_valid,
    input logic             carry_en,
    input logic             ovf_en,
    input logic             rec_en,
    input logic             divovf_valid,
    input logic             divovf_val,
    input logic             imm_valid,
    input logic [CNT_W-1:0] opnd_cnt,
    input logic [1:0]       done_mask,
    input logic             ca,
    input logic             ca32,
    input logic             ov,
    input logic             ov32,
    input logic             so,
    input logic [CR_W-1:0]  cr0
);

    // R2
    hold_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !upd_valid |=> ($stable(ca) && $stable(ca32) && $stable(ov) &&
                        $stable(ov32) && $stable(so) && $stable(cr0)));

    // R11
    carry_off_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && !carry_en) |=> ($stable(ca) && $stable(ca32)));

    // R4
    ca_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && done_mask[0]) |=> $stable(ca));

    // R5
    ca32_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && done_mask[1]) |=> $stable(ca32));

    // R7
    div_ovf_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && ovf_en && divovf_valid) |=>
            ((ov == $past(divovf_val)) && (ov32 == $past(divovf_val))));

    // R8
    few_opnd_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && ovf_en && !divovf_valid && opnd_cnt == '0 && !imm_valid) |=>
            ($stable(ov) && $stable(ov32) && $stable(so)));

    // R9
    so_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        so |=> so);

    // R10
    cr_so_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && rec_en) |=> (cr0[CR_SO] == so));

    // R10
    cr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && !rec_en) |=> $stable(cr0));

endmodule

bind fxflag_unit fxflag_unit_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .upd_valid    (upd_valid),
    .carry_en     (carry_en),
    .ovf_en       (ovf_en),
    .rec_en       (rec_en),
    .divovf_valid (divovf_valid),
    .divovf_val   (divovf_val),
    .imm_valid    (imm_valid),
    .opnd_cnt     (opnd_cnt),
    .done_mask    (done_mask),
    .ca           (ca),
    .ca32         (ca32),
    .ov           (ov),
    .ov32         (ov32),
    .so           (so),
    .cr0          (cr0)
);

// File: tb/fxflag_unit_bench.sv
module fxflag_unit_bench;

    localparam time CYC = 4ns;

    logic        clk = 1'b0;
    logic        rst;
    logic        upd_valid;
    logic [63:0] opnd_a, opnd_b, opnd_c, imm_data, result;
    logic [1:0]  opnd_cnt;
    logic        inv_a, imm_valid, is_add, carry_en, ovf_en, rec_en;
    logic        divovf_valid, divovf_val;
    logic [1:0]  done_mask;
    logic        ca, ca32, ov, ov32, so;
    logic [3:0]  cr0;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #(CYC/2) clk = ~clk;

    fxflag_unit u_fxflag_unit (
        .clk(clk), .rst(rst), .upd_valid(upd_valid),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_c(opnd_c),
        .opnd_cnt(opnd_cnt), .inv_a(inv_a), .imm_valid(imm_valid),
        .imm_data(imm_data), .result(result), .is_add(is_add),
        .carry_en(carry_en), .ovf_en(ovf_en), .rec_en(rec_en),
        .divovf_valid(divovf_valid), .divovf_val(divovf_val),
        .done_mask(done_mask),
        .ca(ca), .ca32(ca32), .ov(ov), .ov32(ov32), .so(so), .cr0(cr0)
    );

    task automatic chk(input string req, input string what,
                       input logic [3:0] got, input logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic expect_all(input string req, input logic eca, input logic eca32,
                              input logic eov, input logic eov32, input logic eso,
                              input logic [3:0] ecr);
        chk(req, "ca",   {3'b0, ca},   {3'b0, eca});
        chk(req, "ca32", {3'b0, ca32}, {3'b0, eca32});
        chk(req, "ov",   {3'b0, ov},   {3'b0, eov});
        chk(req, "ov32", {3'b0, ov32}, {3'b0, eov32});
        chk(req, "so",   {3'b0, so},   {3'b0, eso});
        chk(req, "cr0",  cr0,          ecr);
    endtask

    task automatic clear_in();
        upd_valid = 0; opnd_a = '0; opnd_b = '0; opnd_c = '0; opnd_cnt = '0;
        inv_a = 0; imm_valid = 0; imm_data = '0; result = '0; is_add = 0;
        carry_en = 0; ovf_en = 0; rec_en = 0; divovf_valid = 0; divovf_val = 0;
        done_mask = '0;
    endtask

    // strobe one update; outputs are sampled at the following falling edge
    task automatic pulse();
        @(negedge clk); upd_valid = 1;
        @(negedge clk); upd_valid = 0;
    endtask

    task automatic t_reset();
        clear_in();
        rst = 1;
        @(negedge clk); @(negedge clk);
        rst = 0;
        @(negedge clk);
        expect_all("R1", 0, 0, 0, 0, 0, 4'h0);
    endtask

    task automatic t_no_strobe();
        clear_in();
        carry_en = 1; rec_en = 1; ovf_en = 1; divovf_valid = 1; divovf_val = 1;
        opnd_cnt = 2; opnd_a = 64'd5; opnd_b = 64'd3; result = 64'd2;
        @(negedge clk); @(negedge clk);
        expect_all("R2", 0, 0, 0, 0, 0, 4'h0);
    endtask

    task automatic t_carry();
        // non-add: 5 >u 2 on both widths
        clear_in(); carry_en = 1; opnd_cnt = 2;
        opnd_a = 64'd5; opnd_b = 64'd3; result = 64'd2;
        pulse(); expect_all("R4", 1, 1, 0, 0, 0, 4'h0);
        // add with no carry anywhere
        clear_in(); carry_en = 1; is_add = 1; opnd_cnt = 2;
        opnd_a = 64'd1; opnd_b = 64'd2; result = 64'd3;
        pulse(); expect_all("R5", 0, 0, 0, 0, 0, 4'h0);
        // add: carry into bit 32 only, parity rule gives ca32
        clear_in(); carry_en = 1; is_add = 1; opnd_cnt = 2;
        opnd_a = 64'h0000_0000_FFFF_FFFF; opnd_b = 64'd1; result = 64'h1_0000_0000;
        pulse(); expect_all("R5", 0, 1, 0, 0, 0, 4'h0);
        // add: full carry out, a[32]=1 gives ca32
        clear_in(); carry_en = 1; is_add = 1; opnd_cnt = 2;
        opnd_a = '1; opnd_b = 64'd2; result = 64'd1;
        pulse(); expect_all("R4", 1, 1, 0, 0, 0, 4'h0);
    endtask

    task automatic t_mask();
        // mask bit 1 keeps ca32=1, ca drops to 0
        clear_in(); carry_en = 1; done_mask = 2'b10; opnd_cnt = 2;
        opnd_a = 64'd1; opnd_b = 64'd1; result = 64'd5;
        pulse(); expect_all("R5", 0, 1, 0, 0, 0, 4'h0);
        // mask bit 0 keeps ca=0 although 9 >u 3
        clear_in(); carry_en = 1; done_mask = 2'b01; opnd_cnt = 2;
        opnd_a = 64'd9; opnd_b = 64'd0; result = 64'd3;
        pulse(); expect_all("R4", 0, 1, 0, 0, 0, 4'h0);
    endtask

    task automatic t_carry_off();
        // would give ca=1, ca32=0 if evaluated
        clear_in(); carry_en = 0; opnd_cnt = 1;
        opnd_a = 64'h1_0000_0001; result = 64'd5;
        pulse(); expect_all("R11", 0, 1, 0, 0, 0, 4'h0);
    endtask

    task automatic t_oplist();
        // inverted a = 0xF, not greater than 0x10
        clear_in(); carry_en = 1; opnd_cnt = 1; inv_a = 1;
        opnd_a = 64'hFFFF_FFFF_FFFF_FFF0; result = 64'h10;
        pulse(); expect_all("R3", 0, 0, 0, 0, 0, 4'h0);
        // immediate 0x20 appended after a single operand
        clear_in(); carry_en = 1; opnd_cnt = 1;
        opnd_a = 64'd1; imm_valid = 1; imm_data = 64'h20; result = 64'h10;
        pulse(); expect_all("R3", 1, 1, 0, 0, 0, 4'h0);
    endtask

    task automatic t_overflow();
        clear_in(); ovf_en = 1; is_add = 1; opnd_cnt = 2;
        opnd_a = 64'h7FFF_FFFF_FFFF_FFFF; opnd_b = 64'd1; result = 64'h8000_0000_0000_0000;
        pulse(); expect_all("R6", 1, 1, 1, 0, 1, 4'h0);
        clear_in(); ovf_en = 1; is_add = 1; opnd_cnt = 2;
        opnd_a = 64'h7FFF_FFFF; opnd_b = 64'd1; result = 64'h8000_0000;
        pulse(); expect_all("R9", 1, 1, 0, 1, 1, 4'h0);
        // one operand only: overflow flags held
        clear_in(); ovf_en = 1; opnd_cnt = 1;
        opnd_a = 64'h7FFF_FFFF_FFFF_FFFF; result = 64'h8000_0000_0000_0000;
        pulse(); expect_all("R8", 1, 1, 0, 1, 1, 4'h0);
        // immediate makes the second operand
        clear_in(); ovf_en = 1; opnd_cnt = 1; imm_valid = 1; imm_data = 64'd1;
        opnd_a = 64'h7FFF_FFFF_FFFF_FFFF; result = 64'h8000_0000_0000_0000;
        pulse(); expect_all("R6", 1, 1, 1, 0, 1, 4'h0);
    endtask

    task automatic t_divovf();
        clear_in(); ovf_en = 1; divovf_valid = 1; divovf_val = 0;
        pulse(); expect_all("R7", 1, 1, 0, 0, 1, 4'h0);
        clear_in(); ovf_en = 1; divovf_valid = 1; divovf_val = 1;
        pulse(); expect_all("R7", 1, 1, 1, 1, 1, 4'h0);
    endtask

    task automatic t_cr();
        clear_in(); rec_en = 1; result = 64'd0;
        pulse(); expect_all("R10", 1, 1, 1, 1, 1, 4'b0011);
        clear_in(); rec_en = 1; result = 64'hFFFF_FFFF_FFFF_FFFE;
        pulse(); expect_all("R10", 1, 1, 1, 1, 1, 4'b1001);
        clear_in(); rec_en = 1; result = 64'd5;
        pulse(); expect_all("R10", 1, 1, 1, 1, 1, 4'b0101);
        clear_in(); rec_en = 0; result = 64'd0;
        pulse(); expect_all("R10", 1, 1, 1, 1, 1, 4'b0101);
    endtask

    task automatic t_cr_same_edge();
        t_reset();
        clear_in(); ovf_en = 1; rec_en = 1; is_add = 1; opnd_cnt = 2;
        opnd_a = 64'h7FFF_FFFF_FFFF_FFFF; opnd_b = 64'd1; result = 64'h8000_0000_0000_0000;
        pulse(); expect_all("R10", 0, 0, 1, 0, 1, 4'b1001);
        t_reset();
        clear_in(); rec_en = 1; result = 64'd5;
        pulse(); expect_all("R10", 0, 0, 0, 0, 0, 4'b0100);
    endtask

    initial begin
        clear_in();
        rst = 1;
        t_reset();
        t_no_strobe();
        t_carry();
        t_mask();
        t_carry_off();
        t_oplist();
        t_overflow();
        t_divovf();
        t_cr();
        t_reset();
        t_cr_same_edge();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CYC * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule